// File: doc/BRIEF.md
# ECC Memory Initialization Sweeper

The sweeper prepares an ECC-protected DRAM array for normal operation. After power-up the check bits stored beside each word are arbitrary, so a plain read would report errors that are not real. While its initialize mode is active, the block steps through every location of the array. It writes each location with a fixed data pattern while asking the memory port to generate fresh check bits. Once the sweep is complete, a later normal-mode read of any location reports no error.

Software controls the mode through two bus reads. A read of the diagnostic latch address starts the mode, but only when the controller is in pass-through mode with fast refresh enabled. That latch takes no part in normal reads, so reading it has no other effect. A read of the control/status register address ends the mode at any point.

Refresh requests always win over the sweep. While a refresh is granted, the sweep pauses. It then carries on from where it stopped. The sweep length is the product of the memory depth and the cycles spent on each location. With the default parameters this is 1,048,576 locations at 125 cycles each, which is 131,072,000 cycles or about 5.24 s at 25 MHz. Software must wait for the done indication before it switches the controller to normal mode.

Top module: `ecc_init_sweeper`

## Requirements
- R1: When the block is idle, a cycle with `bus_rd`=1, `bus_addr`=DIAG_ADDR, `ctl_passthru`=1 and `ctl_fast_refresh`=1 starts the mode. From the next cycle on, `init_busy`=1, `init_done`=0 and `mem_addr`=0.
- R2: When the block is idle, any other bus cycle leaves all outputs in the idle state. This covers a diagnostic read with `ctl_passthru`=0 or `ctl_fast_refresh`=0, and a read of any address other than DIAG_ADDR.
- R3: A cycle with `bus_rd`=1 and `bus_addr`=CSR_ADDR, taken while busy or done, returns the block to idle on the next cycle: `init_busy`=0, `init_done`=0, `mem_ckgen_en`=0 and `mem_addr`=0.
- R4: Each location gets exactly one write during a sweep, in ascending order from 0 to MEM_DEPTH-1. `mem_we` is high on the CYC_PER_LOC-th unstalled cycle that the sweep spends on a location. On every write, `mem_wdata`=INIT_PATTERN and `mem_ckgen_en`=1.
- R5: If no exit read occurs, `init_busy` stays high for exactly MEM_DEPTH*CYC_PER_LOC cycles in which `refresh_req`=0, plus any stalled cycles.
- R6: In the cycle after the write to location MEM_DEPTH-1, `init_done`=1 and `init_busy`=0. Done then holds, with no further writes and `mem_addr` held, until an exit read or a reset.
- R7: While `refresh_req`=1, `mem_we`=0 and the sweep makes no progress: both `mem_addr` and the position within the current location hold. After the refresh, no address is skipped.
- R8: A diagnostic-address read that occurs while busy or done has no effect. The sweep does not restart, and `mem_addr` keeps its value.
- R9: A synchronous `rst`=1 returns the block to idle with `mem_addr`=0 on the next cycle, whatever state it was in.
- R10: Outside the mode (`init_busy`=0 and `init_done`=0), `mem_we`=0 and `mem_ckgen_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | One-cycle bus read strobe |
| bus_addr | input | BUS_AW | Bus address qualified by `bus_rd` |
| ctl_passthru | input | 1 | Controller is in pass-through mode |
| ctl_fast_refresh | input | 1 | Fast refresh is enabled |
| refresh_req | input | 1 | Refresh granted this cycle; stalls the sweep |
| mem_addr | output | MEM_AW | Sweep address toward the memory port |
| mem_we | output | 1 | Write strobe toward the memory port |
| mem_wdata | output | DATA_W | Write data (INIT_PATTERN) |
| mem_ckgen_en | output | 1 | Memory port generates check bits for writes |
| init_busy | output | 1 | Sweep in progress |
| init_done | output | 1 | Sweep finished; holds until exit |

## Verification
The assertions check the following rules on every cycle:
- entry is gated on pass-through mode and fast refresh;
- exit returns the block to idle;
- the address moves up by exactly one after each write;
- the address holds during stalls and re-entry reads;
- no write occurs while a refresh is granted or outside the mode;
- done holds once it is reached.

Some properties cover a whole sweep rather than a single cycle, so only the bench scenarios can show them. These are that every location from 0 to the last is written exactly once, and that the busy time equals depth times slot length once stall cycles are excluded. The same holds for the sweep resuming correctly after refresh windows and after an aborted sweep or a reset in mid-sweep.

// File: rtl/ecc_init_pkg.sv
package ecc_init_pkg;

    typedef enum logic [1:0] {
        SWP_IDLE = 2'd0,
        SWP_RUN  = 2'd1,
        SWP_DONE = 2'd2
    } swp_state_e;

    typedef struct packed {
        logic enter;
        logic leave;
    } swp_cmd_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ecc_init_decode.sv
module ecc_init_decode
    import ecc_init_pkg::*;
#(
    parameter int unsigned          BUS_AW    = 16,
    parameter logic [BUS_AW-1:0]    DIAG_ADDR = 16'hFF00,
    parameter logic [BUS_AW-1:0]    CSR_ADDR  = 16'hFF04
) (
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              ctl_passthru,
    input  logic              ctl_fast_refresh,
    output swp_cmd_t          cmd
);

    logic hit_diag;
    logic hit_csr;
    logic entry_allowed;

    assign hit_diag      = bus_rd && (bus_addr == DIAG_ADDR);
    assign hit_csr       = bus_rd && (bus_addr == CSR_ADDR);
    assign entry_allowed = ctl_passthru && ctl_fast_refresh;

    always_comb begin
        cmd       = '0;
        cmd.enter = hit_diag && entry_allowed;
        cmd.leave = hit_csr;
    end

endmodule

// File: rtl/ecc_init_walker.sv
module ecc_init_walker
    import ecc_init_pkg::*;
#(
    parameter int unsigned MEM_DEPTH   = 1048576,
    parameter int unsigned CYC_PER_LOC = 125,
    localparam int unsigned MEM_AW     = cnt_width(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              run,
    output logic [MEM_AW-1:0] addr,
    output logic              slot_last,
    output logic              loc_last
);

    localparam logic [MEM_AW-1:0] LAST_LOC = MEM_AW'(MEM_DEPTH - 1);

    assign loc_last = (addr == LAST_LOC);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            addr <= '0;
        end else if (run && slot_last && !loc_last) begin
            addr <= addr + 1'b1;
        end
    end

    generate
        if (CYC_PER_LOC <= 1) begin : g_single
            assign slot_last = 1'b1;
        end else begin : g_multi
            localparam int unsigned TW = cnt_width(CYC_PER_LOC);
            localparam logic [TW-1:0] LAST_TICK = TW'(CYC_PER_LOC - 1);
            logic [TW-1:0] tick;

            assign slot_last = (tick == LAST_TICK);

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    tick <= '0;
                end else if (run) begin
                    tick <= slot_last ? '0 : tick + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ecc_init_ctrl.sv
module ecc_init_ctrl
    import ecc_init_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  swp_cmd_t   cmd,
    input  logic       refresh_req,
    input  logic       slot_last,
    input  logic       loc_last,
    output swp_state_e state,
    output logic       walk_clr,
    output logic       walk_run
);

    swp_state_e state_nx;

    assign walk_clr = ((state == SWP_IDLE) && cmd.enter) ||
                      ((state != SWP_IDLE) && cmd.leave);
    assign walk_run = (state == SWP_RUN) && !refresh_req;

    always_comb begin
        state_nx = state;
        unique case (state)
            SWP_IDLE: if (cmd.enter) state_nx = SWP_RUN;
            SWP_RUN: begin
                if (cmd.leave)
                    state_nx = SWP_IDLE;
                else if (walk_run && slot_last && loc_last)
                    state_nx = SWP_DONE;
            end
            SWP_DONE: if (cmd.leave) state_nx = SWP_IDLE;
            default:  state_nx = SWP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SWP_IDLE;
        else     state <= state_nx;
    end

endmodule

// File: rtl/ecc_init_sweeper.sv
module ecc_init_sweeper
    import ecc_init_pkg::*;
#(
    parameter int unsigned          BUS_AW       = 16,
    parameter logic [BUS_AW-1:0]    DIAG_ADDR    = 16'hFF00,
    parameter logic [BUS_AW-1:0]    CSR_ADDR     = 16'hFF04,
    parameter int unsigned          MEM_DEPTH    = 1048576,
    parameter int unsigned          CYC_PER_LOC  = 125,
    parameter int unsigned          DATA_W       = 32,
    parameter logic [DATA_W-1:0]    INIT_PATTERN = '0,
    localparam int unsigned         MEM_AW       = cnt_width(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              ctl_passthru,
    input  logic              ctl_fast_refresh,
    input  logic              refresh_req,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_ckgen_en,
    output logic              init_busy,
    output logic              init_done
);

    swp_cmd_t   cmd;
    swp_state_e state;
    logic       walk_clr;
    logic       walk_run;
    logic       slot_last;
    logic       loc_last;

    ecc_init_decode #(
        .BUS_AW    (BUS_AW),
        .DIAG_ADDR (DIAG_ADDR),
        .CSR_ADDR  (CSR_ADDR)
    ) decode_i (
        .bus_rd           (bus_rd),
        .bus_addr         (bus_addr),
        .ctl_passthru     (ctl_passthru),
        .ctl_fast_refresh (ctl_fast_refresh),
        .cmd              (cmd)
    );

    ecc_init_ctrl ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .refresh_req (refresh_req),
        .slot_last   (slot_last),
        .loc_last    (loc_last),
        .state       (state),
        .walk_clr    (walk_clr),
        .walk_run    (walk_run)
    );

    ecc_init_walker #(
        .MEM_DEPTH   (MEM_DEPTH),
        .CYC_PER_LOC (CYC_PER_LOC)
    ) walker_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (walk_clr),
        .run       (walk_run),
        .addr      (mem_addr),
        .slot_last (slot_last),
        .loc_last  (loc_last)
    );

    assign init_busy    = (state == SWP_RUN);
    assign init_done    = (state == SWP_DONE);
    assign mem_ckgen_en = (state != SWP_IDLE);
    assign mem_we       = init_busy && slot_last && !refresh_req;
    assign mem_wdata    = INIT_PATTERN;

endmodule

// File: rtl/ecc_init_sweeper_chk.sv
module ecc_init_sweeper_chk #(
    parameter int unsigned       BUS_AW    = 16,
    parameter logic [BUS_AW-1:0] DIAG_ADDR = 16'hFF00,
    parameter logic [BUS_AW-1:0] CSR_ADDR  = 16'hFF04,
    parameter int unsigned       MEM_DEPTH = 1048576,
    parameter int unsigned       MEM_AW    = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              ctl_passthru,
    input logic              ctl_fast_refresh,
    input logic              refresh_req,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_ckgen_en,
    input logic              init_busy,
    input logic              init_done
);

    localparam logic [MEM_AW-1:0] LAST_LOC = MEM_AW'(MEM_DEPTH - 1);

    logic rd_diag;
    logic rd_csr;
    logic idle;
    assign rd_diag = bus_rd && (bus_addr == DIAG_ADDR);
    assign rd_csr  = bus_rd && (bus_addr == CSR_ADDR);
    assign idle    = !init_busy && !init_done;

    assert_enter_R1: assert property (@(posedge clk) disable iff (rst)
        idle && rd_diag && ctl_passthru && ctl_fast_refresh |=> init_busy && (mem_addr == '0));

    assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
        idle && !(rd_diag && ctl_passthru && ctl_fast_refresh) |=> !init_busy && !init_done);

    assert_exit_R3: assert property (@(posedge clk) disable iff (rst)
        !idle && rd_csr |=> idle && (mem_addr == '0));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        init_busy && mem_we && !rd_csr && (mem_addr != LAST_LOC)
        |=> init_busy && (mem_addr == MEM_AW'($past(mem_addr) + 1'b1)));

    assert_ckgen_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_ckgen_en);

    assert_finish_R6: assert property (@(posedge clk) disable iff (rst)
        init_busy && mem_we && !rd_csr && (mem_addr == LAST_LOC) |=> init_done && !init_busy);

    assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
        init_done && !rd_csr |=> init_done && $stable(mem_addr) && !mem_we);

    assert_excl_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({init_busy, init_done}));

    assert_no_we_refresh_R7: assert property (@(posedge clk) disable iff (rst)
        refresh_req |-> !mem_we);

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        init_busy && !mem_we && !rd_csr |=> $stable(mem_addr));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        idle |-> !mem_we && !mem_ckgen_en);

endmodule

bind ecc_init_sweeper ecc_init_sweeper_chk #(
    .BUS_AW    (BUS_AW),
    .DIAG_ADDR (DIAG_ADDR),
    .CSR_ADDR  (CSR_ADDR),
    .MEM_DEPTH (MEM_DEPTH),
    .MEM_AW    (MEM_AW)
) chk_i (
    .clk              (clk),
    .rst              (rst),
    .bus_rd           (bus_rd),
    .bus_addr         (bus_addr),
    .ctl_passthru     (ctl_passthru),
    .ctl_fast_refresh (ctl_fast_refresh),
    .refresh_req      (refresh_req),
    .mem_addr         (mem_addr),
    .mem_we           (mem_we),
    .mem_ckgen_en     (mem_ckgen_en),
    .init_busy        (init_busy),
    .init_done        (init_done)
);

// File: tb/ecc_init_sweeper_tb.sv
module ecc_init_sweeper_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          BUS_AW     = 8;
    localparam logic [7:0]  DIAG       = 8'hA5;
    localparam logic [7:0]  CSR        = 8'h10;
    localparam int          DEPTH      = 8;
    localparam int          CPL        = 3;
    localparam int          DATA_W     = 32;
    localparam logic [31:0] PATTERN    = 32'hC3C3_3C3C;
    localparam int          MEM_AW     = 3;
    localparam int          WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_rd = 1'b0;
    logic [BUS_AW-1:0] bus_addr = '0;
    logic              ctl_passthru = 1'b0;
    logic              ctl_fast_refresh = 1'b0;
    logic              refresh_req = 1'b0;
    logic [MEM_AW-1:0] mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ckgen_en;
    logic              init_busy;
    logic              init_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_init_sweeper #(
        .BUS_AW       (BUS_AW),
        .DIAG_ADDR    (DIAG),
        .CSR_ADDR     (CSR),
        .MEM_DEPTH    (DEPTH),
        .CYC_PER_LOC  (CPL),
        .DATA_W       (DATA_W),
        .INIT_PATTERN (PATTERN)
    ) dut_i (
        .clk              (clk),
        .rst              (rst),
        .bus_rd           (bus_rd),
        .bus_addr         (bus_addr),
        .ctl_passthru     (ctl_passthru),
        .ctl_fast_refresh (ctl_fast_refresh),
        .refresh_req      (refresh_req),
        .mem_addr         (mem_addr),
        .mem_we           (mem_we),
        .mem_wdata        (mem_wdata),
        .mem_ckgen_en     (mem_ckgen_en),
        .init_busy        (init_busy),
        .init_done        (init_done)
    );

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit finished = 1'b0;

    // behavioural reference: 0 idle, 1 sweeping, 2 finished
    int m_st = 0;
    int m_addr = 0;
    int m_tick = 0;
    bit m_ent, m_lv;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_addr = 0; m_tick = 0;
        end else begin
            m_ent = bus_rd && (bus_addr == DIAG) && ctl_passthru && ctl_fast_refresh;
            m_lv  = bus_rd && (bus_addr == CSR);
            if (m_st == 0) begin
                if (m_ent) begin m_st = 1; m_addr = 0; m_tick = 0; end
            end else if (m_lv) begin
                m_st = 0; m_addr = 0; m_tick = 0;
            end else if (m_st == 1 && !refresh_req) begin
                if (m_tick == CPL - 1) begin
                    m_tick = 0;
                    if (m_addr == DEPTH - 1) m_st = 2;
                    else m_addr = m_addr + 1;
                end else begin
                    m_tick = m_tick + 1;
                end
            end
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    bit track = 1'b0;
    int wr_q[$];
    int run_cnt = 0;

    always @(negedge clk) begin
        #1;
        if (!rst && !finished) begin
            check("R1/R3/R6 init_busy", init_busy, m_st == 1);
            check("R6 init_done", init_done, m_st == 2);
            check("R4/R7 mem_addr", mem_addr, m_addr);
            check("R4/R7 mem_we", mem_we, (m_st == 1) && (m_tick == CPL - 1) && !refresh_req);
            check("R10 mem_ckgen_en", mem_ckgen_en, m_st != 0);
            if (mem_we) check("R4 mem_wdata", mem_wdata, PATTERN);
            if (track) begin
                if (mem_we) wr_q.push_back(int'(mem_addr));
                if (init_busy && !refresh_req) run_cnt++;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic tick_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, input bit pt, input bit fr);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; ctl_passthru = pt; ctl_fast_refresh = fr;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 8'h00;
    endtask

    initial begin
        int held;
        tick_n(3);
        rst = 1'b0;
        @(negedge clk); #2;
        // R9 reset state
        check("R9 busy after reset", init_busy, 0);
        check("R9 done after reset", init_done, 0);
        check("R9 addr after reset", mem_addr, 0);
        check("R10 quiet after reset", {mem_we, mem_ckgen_en}, 0);

        // R2 gated or foreign entry attempts
        bus_read(DIAG, 1'b0, 1'b1); #2;
        check("R2 no entry without passthru", init_busy, 0);
        bus_read(DIAG, 1'b1, 1'b0); #2;
        check("R2 no entry without fast refresh", init_busy, 0);
        bus_read(8'h5A, 1'b1, 1'b1); #2;
        check("R2 no entry on other address", {init_busy, init_done, mem_ckgen_en}, 0);

        // R1 entry, full sweep with stalls
        track = 1'b1; run_cnt = 0; wr_q.delete();
        bus_read(DIAG, 1'b1, 1'b1); #2;
        check("R1 busy after entry", init_busy, 1);
        check("R1 addr zero after entry", mem_addr, 0);
        tick_n(4);
        // R7 refresh stall window
        held = int'(mem_addr);
        refresh_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #2;
            check("R7 addr frozen during refresh", mem_addr, held);
            check("R7 no write during refresh", mem_we, 0);
        end
        @(negedge clk); refresh_req = 1'b0;
        tick_n(2);
        // R8 re-entry mid-sweep
        held = int'(mem_addr);
        bus_read(DIAG, 1'b1, 1'b1); #2;
        check("R8 no restart mid-sweep", int'(mem_addr) >= held && held > 0, 1);
        for (int i = 0; i < 400 && !init_done; i++) begin
            @(negedge clk);
            refresh_req = (i % 7 == 3) || (i % 7 == 4);
        end
        @(negedge clk); refresh_req = 1'b0;
        track = 1'b0;
        #2;
        check("R6 done after sweep", init_done, 1);
        check("R4 write count", wr_q.size(), DEPTH);
        for (int i = 0; i < wr_q.size(); i++)
            check("R4 write order", wr_q[i], i);
        check("R5 sweep length", run_cnt, DEPTH * CPL);

        // R6 done holds, R8 re-entry while done
        tick_n(10); #2;
        check("R6 done holds", {init_done, init_busy}, 2'b10);
        check("R6 addr held at last", mem_addr, DEPTH - 1);
        bus_read(DIAG, 1'b1, 1'b1); #2;
        check("R8 entry while done ignored", {init_done, init_busy}, 2'b10);

        // R3 exit from done
        bus_read(CSR, 1'b1, 1'b1); #2;
        check("R3 idle after exit", {init_busy, init_done, mem_ckgen_en}, 0);
        check("R10 no write when idle", mem_we, 0);

        // R3 exit mid-sweep
        bus_read(DIAG, 1'b1, 1'b1);
        tick_n(7);
        bus_read(CSR, 1'b0, 1'b0); #2;
        check("R3 exit mid-sweep busy", init_busy, 0);
        check("R3 exit mid-sweep addr", mem_addr, 0);

        // R9 reset mid-sweep
        bus_read(DIAG, 1'b1, 1'b1);
        tick_n(8);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #2;
        check("R9 reset mid-sweep", {init_busy, init_done}, 0);
        check("R9 addr after mid-sweep reset", mem_addr, 0);

        // R1 fresh sweep restarts from zero
        bus_read(DIAG, 1'b1, 1'b1); #2;
        check("R1 re-entry addr zero", mem_addr, 0);
        tick_n(3);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule